// File: doc/BRIEF.md
# Smart Card Character UART

This block is the character layer between a host and the single bidirectional I/O line of an asynchronous smart card. The line is open-drain: the block either pulls it low or releases it, and it reads the resolved level back. Bit timing comes from a programmable clock-per-ETU divider. Each character is a start bit, eight data bits and an even parity bit. A transmitted character occupies at least twelve ETUs, and a programmable number of extra guard ETUs can be added after it.

After reset the block waits for the card's initial character. That character fixes the bit convention for the rest of the session, and from then on the block translates in both directions, so the host only ever handles plain byte values. In T=0 mode, parity errors are handled per character. When the receiver sees a bad character, it pulls the line low in the guard slot and drops the character. When the transmitter sees such a pulse, it sends the character again, up to a programmed retry limit. Received characters go into a small FIFO, which raises an interrupt when it holds as many characters as the programmed threshold.

The host reaches everything through an 8-bit register port with a 3-bit address. Read data is registered and is valid one cycle after the read strobe.

Top module: `sc_char_uart`

## Requirements
- R1: After reset: CTRL (address 0) reads 0x07, the ETU divider (address 1) reads 16, extra guard (address 2) reads 0, STATUS (address 5) reads 0x20, the line is released (io_drv_low low) and irq is low.
- R2: Writes to CTRL, the ETU divider and extra guard read back. CTRL fields: bit0 enables T=0 error handling, bits3:1 hold the retry limit, bits6:4 hold the FIFO threshold minus one. Bit7 of CTRL is write-only, reads as 0, and writing it as 1 clears the sticky flags.
- R3: If the first character's raw line bits, taken LSB first with high read as 1, equal 0x3B, the block selects direct convention: STATUS bit0 becomes 1, bit1 stays 0, and 0x3B is stored in the FIFO.
- R4: If the first character's raw bits equal 0x03, the block selects inverse convention: STATUS bit0 and bit1 become 1 and 0x3F is stored. In inverse convention a low line is a logical 1 and the first data bit is the MSB, for both receive and transmit.
- R5: In direct convention a high line is 1, data is LSB first, and parity makes the count of ones over data and parity even. Good characters are read from address 4 in arrival order, and each read removes one.
- R6: In T=0 mode, a received character with bad parity makes the block pull the line low from 10.5 to 11.5 ETU after its start bit. The character is not stored, and the receive error count (address 6, bits3:0, saturating at 15) increments.
- R7: With T=0 disabled, a character with bad parity is stored without any line pulse and is still counted.
- R8: Writing address 3 sends a start bit, eight data bits and a parity bit in the selected convention (direct if none has been selected yet). The line is released from 10 ETU onward.
- R9: In T=0 mode, a low line at 10.5 ETU marks a transmit error. It increments the transmit error count (address 6, bits7:4) and causes a resend, up to the retry limit. After the last allowed attempt fails, sticky STATUS bit3 is set.
- R10: A resend starts exactly 13 + extra-guard ETUs after the previous start. STATUS bit2 (transmitter busy) stays high until 12 + extra-guard ETUs after the start of an accepted character.
- R11: irq is high while the FIFO count (address 7) is at least the threshold.
- R12: A character that arrives while the FIFO is full is dropped and sets sticky STATUS bit4. The FIFO contents are unchanged, and CTRL bit7 clears the flag.
- R13: A write to address 3 while the transmitter is busy is ignored.
- R14: Any write to address 6 clears both error counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| io_in | input | 1 | Resolved card I/O line level |
| io_drv_low | output | 1 | Pull the I/O line low when high |
| irq | output | 1 | FIFO threshold reached |

## Verification
The bench models the card on a wired-AND line. It checks both initial-character patterns; a design that mixed them up would store the wrong byte and then misdecode every later character. It corrupts parity in both T=0 and T=1 modes and measures the line at 11 ETU. A wrong pulse window would either go unseen by the card or fall onto the next start bit. It makes every transmit attempt fail until the retry limit and measures the spacing between starts, which exposes an off-by-one in the retry count or in the guard arithmetic. It also fills the FIFO past its depth; a design that overwrote entries would return the ninth byte instead of the first eight.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_ETU  = 3'd1,
    A_EGT  = 3'd2,
    A_TXD  = 3'd3,
    A_RXD  = 3'd4,
    A_STAT = 3'd5,
    A_ERRC = 3'd6,
    A_FCNT = 3'd7
  } reg_addr_e;

  localparam logic [7:0] TS_DIRECT_RAW  = 8'h3B;
  localparam logic [7:0] TS_INVERSE_RAW = 8'h03;
  localparam logic [7:0] TS_INVERSE_VAL = 8'h3F;
endpackage

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  // storage written without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) begin
        rp   <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        dout <= mem[rp];
      end else if (pop) begin
        dout <= '0;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int ETU_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_s,
  input  logic             hold,
  input  logic [ETU_W-1:0] etu_div,
  input  logic             t0_mode,
  output logic             busy,
  output logic             drv_low,
  output logic             push,
  output logic [7:0]       pdata,
  output logic             perr_evt,
  output logic             conv_known,
  output logic             conv_inv
);
  import sc_uart_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_SIG} rx_st_e;
  rx_st_e            st;
  logic [ETU_W-1:0]  cnt;
  logic [3:0]        idx;
  logic [8:0]        raw;
  logic              line_q;
  logic [7:0]        dec;
  logic              bad_par;

  wire [ETU_W-1:0] half    = etu_div >> 1;
  wire             etu_end = (cnt == etu_div - 1'b1);
  wire             mid     = (cnt == half);

  assign busy = (st != S_IDLE);

  always_comb begin
    for (int k = 0; k < 8; k++) dec[7-k] = conv_inv ? ~raw[k] : raw[7-k];
    bad_par = conv_inv ? ~(^raw) : (^raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      raw        <= '0;
      line_q     <= 1'b1;
      drv_low    <= 1'b0;
      push       <= 1'b0;
      pdata      <= '0;
      perr_evt   <= 1'b0;
      conv_known <= 1'b0;
      conv_inv   <= 1'b0;
    end else begin
      line_q   <= line_s;
      push     <= 1'b0;
      perr_evt <= 1'b0;
      if (st != S_IDLE) begin
        if (etu_end) begin
          cnt <= '0;
          idx <= idx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (!hold && line_q && !line_s) begin
          st  <= S_BITS;
          cnt <= '0;
          idx <= '0;
        end
        S_BITS: if (mid) begin
          if (idx == 4'd0) begin
            if (line_s) st <= S_IDLE;
          end else if (idx <= 4'd9) begin
            raw <= {line_s, raw[8:1]};
          end else begin
            st <= S_IDLE;
            if (!conv_known) begin
              if (raw[7:0] == TS_DIRECT_RAW) begin
                conv_known <= 1'b1;
                conv_inv   <= 1'b0;
                push       <= 1'b1;
                pdata      <= TS_DIRECT_RAW;
              end else if (raw[7:0] == TS_INVERSE_RAW) begin
                conv_known <= 1'b1;
                conv_inv   <= 1'b1;
                push       <= 1'b1;
                pdata      <= TS_INVERSE_VAL;
              end
            end else if (bad_par) begin
              perr_evt <= 1'b1;
              if (t0_mode) begin
                drv_low <= 1'b1;
                st      <= S_SIG;
              end else begin
                push  <= 1'b1;
                pdata <= dec;
              end
            end else begin
              push  <= 1'b1;
              pdata <= dec;
            end
          end
        end
        S_SIG: if (mid && idx == 4'd11) begin
          drv_low <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int ETU_W = 8,
  parameter int EGT_W = 8,
  parameter int RTY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_s,
  input  logic             start,
  input  logic [7:0]       din,
  input  logic             rx_busy,
  input  logic [ETU_W-1:0] etu_div,
  input  logic [EGT_W-1:0] egt,
  input  logic             t0_mode,
  input  logic             conv_inv,
  input  logic [RTY_W-1:0] rty_limit,
  output logic             busy,
  output logic             drv_low,
  output logic             err_evt,
  output logic             fail_evt
);
  localparam int IW = EGT_W + 2;

  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_RUN} tx_st_e;
  tx_st_e            st;
  logic [ETU_W-1:0]  cnt;
  logic [IW-1:0]     idx;
  logic [8:0]        frame, enc;
  logic              err;
  logic [RTY_W-1:0]  rty;
  logic              drv_nx;

  wire [ETU_W-1:0] half    = etu_div >> 1;
  wire             etu_end = (cnt == etu_div - 1'b1);
  wire             mid     = (cnt == half);
  wire [IW-1:0]    end_idx = IW'(12) + IW'(egt) + IW'(err);

  assign busy = (st != T_IDLE);

  always_comb begin
    for (int k = 0; k < 8; k++) enc[k] = conv_inv ? ~din[7-k] : din[k];
    enc[8] = conv_inv ? ~(^din) : (^din);
  end

  always_comb begin
    drv_nx = 1'b0;
    if (st == T_RUN) begin
      if (idx == '0) drv_nx = 1'b1;
      else if (idx <= IW'(9)) drv_nx = ~frame[idx[3:0] - 4'd1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      cnt      <= '0;
      idx      <= '0;
      frame    <= '0;
      err      <= 1'b0;
      rty      <= '0;
      drv_low  <= 1'b0;
      err_evt  <= 1'b0;
      fail_evt <= 1'b0;
    end else begin
      drv_low  <= drv_nx;
      err_evt  <= 1'b0;
      fail_evt <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          frame <= enc;
          rty   <= '0;
          st    <= T_WAIT;
        end
        T_WAIT: if (!rx_busy) begin
          st  <= T_RUN;
          cnt <= '0;
          idx <= '0;
          err <= 1'b0;
        end
        T_RUN: begin
          if (mid && idx == IW'(10) && t0_mode && !line_s) begin
            err     <= 1'b1;
            err_evt <= 1'b1;
          end
          if (etu_end) begin
            cnt <= '0;
            if (idx + 1'b1 == end_idx) begin
              if (err && rty < rty_limit) begin
                rty <= rty + 1'b1;
                idx <= '0;
                err <= 1'b0;
              end else begin
                fail_evt <= err;
                st       <= T_IDLE;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_uart.sv
module sc_char_uart #(
  parameter int          DEPTH   = 8,
  parameter int          CNT_W   = 4,
  parameter logic [7:0]  ETU_RST = 8'd16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       io_in,
  output logic       io_drv_low,
  output logic       irq
);
  import sc_uart_pkg::*;

  localparam int FCW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             t0_mode;
  logic [2:0]       rty_limit, lvl_f;
  logic [7:0]       etu_div, egt;
  logic             overrun, tx_fail;
  logic [CNT_W-1:0] rx_perr, tx_perr;
  logic             sync1, line_s;
  logic [7:0]       rdata_q;
  logic             rd_fifo_q;

  logic             rx_busy, rx_drv, rx_push, rx_perr_evt, conv_known, conv_inv;
  logic [7:0]       rx_data;
  logic             tx_busy, tx_drv, tx_err_evt, tx_fail_evt;
  logic [7:0]       fifo_dout;
  logic [FCW-1:0]   fifo_cnt;
  logic             fifo_full, fifo_empty;

  wire wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  wire clr_flags = wr_ctrl && bus_wdata[7];
  wire clr_cnt   = bus_wr && bus_addr == A_ERRC;
  wire tx_start  = bus_wr && bus_addr == A_TXD;
  wire fifo_pop  = bus_rd && bus_addr == A_RXD;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b1;
      line_s <= 1'b1;
    end else begin
      sync1  <= io_in;
      line_s <= sync1;
    end
  end

  sc_char_rx #(.ETU_W(8)) rx_i (
    .clk, .rst, .line_s, .hold(tx_busy), .etu_div, .t0_mode,
    .busy(rx_busy), .drv_low(rx_drv), .push(rx_push), .pdata(rx_data),
    .perr_evt(rx_perr_evt), .conv_known, .conv_inv
  );

  sc_char_tx #(.ETU_W(8), .EGT_W(8), .RTY_W(3)) tx_i (
    .clk, .rst, .line_s, .start(tx_start), .din(bus_wdata), .rx_busy,
    .etu_div, .egt, .t0_mode, .conv_inv, .rty_limit,
    .busy(tx_busy), .drv_low(tx_drv), .err_evt(tx_err_evt), .fail_evt(tx_fail_evt)
  );

  sc_rx_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
    .clk, .rst, .push(rx_push), .din(rx_data), .pop(fifo_pop),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  assign io_drv_low = rx_drv | tx_drv;

  always_ff @(posedge clk) begin
    if (rst) begin
      t0_mode   <= 1'b1;
      rty_limit <= 3'd3;
      lvl_f     <= 3'd0;
      etu_div   <= ETU_RST;
      egt       <= 8'd0;
      overrun   <= 1'b0;
      tx_fail   <= 1'b0;
      rx_perr   <= '0;
      tx_perr   <= '0;
      irq       <= 1'b0;
      rdata_q   <= '0;
      rd_fifo_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        t0_mode   <= bus_wdata[0];
        rty_limit <= bus_wdata[3:1];
        lvl_f     <= bus_wdata[6:4];
      end
      if (bus_wr && bus_addr == A_ETU) etu_div <= bus_wdata;
      if (bus_wr && bus_addr == A_EGT) egt     <= bus_wdata;

      if (rx_push && fifo_full) overrun <= 1'b1;
      else if (clr_flags)       overrun <= 1'b0;
      if (tx_fail_evt)          tx_fail <= 1'b1;
      else if (clr_flags)       tx_fail <= 1'b0;

      if (clr_cnt) begin
        rx_perr <= '0;
        tx_perr <= '0;
      end else begin
        if (rx_perr_evt && rx_perr != CNT_MAX) rx_perr <= rx_perr + 1'b1;
        if (tx_err_evt  && tx_perr != CNT_MAX) tx_perr <= tx_perr + 1'b1;
      end

      irq <= (int'(fifo_cnt) >= int'(lvl_f) + 1);

      rd_fifo_q <= fifo_pop;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  rdata_q <= {1'b0, lvl_f, rty_limit, t0_mode};
          A_ETU:   rdata_q <= etu_div;
          A_EGT:   rdata_q <= egt;
          A_STAT:  rdata_q <= {rx_busy, irq, fifo_empty, overrun, tx_fail,
                               tx_busy, conv_inv, conv_known};
          A_ERRC:  rdata_q <= {4'(tx_perr), 4'(rx_perr)};
          A_FCNT:  rdata_q <= 8'(fifo_cnt);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_fifo_q ? fifo_dout : rdata_q;
endmodule

// File: rtl/sc_char_uart_chk.sv
module sc_char_uart_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       rx_push,
  input logic                       fifo_full,
  input logic                       fifo_pop,
  input logic                       rx_drv,
  input logic                       tx_drv,
  input logic                       tx_fail,
  input logic                       clr_flags,
  input logic                       conv_known,
  input logic [3:0]                 rx_perr,
  input logic                       clr_cnt
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_cnt) <= DEPTH); // R12

  AST_FULL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (rx_push && fifo_full && !fifo_pop) |=> (fifo_cnt == $past(fifo_cnt))); // R12

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    !(rx_drv && tx_drv)); // R6

  AST_TXFAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_fail && !clr_flags) |=> tx_fail); // R9

  AST_CONV_STICKY: assert property (@(posedge clk) disable iff (rst)
    conv_known |=> conv_known); // R3

  AST_PERR_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (rx_perr == 4'hF && !clr_cnt) |=> (rx_perr == 4'hF)); // R14
endmodule

bind sc_char_uart sc_char_uart_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .fifo_cnt(fifo_cnt), .rx_push(rx_push),
  .fifo_full(fifo_full), .fifo_pop(fifo_pop), .rx_drv(rx_drv), .tx_drv(tx_drv),
  .tx_fail(tx_fail), .clr_flags(clr_flags), .conv_known(conv_known),
  .rx_perr(rx_perr), .clr_cnt(clr_cnt)
);

// File: tb/sc_char_uart_tb.sv
module sc_char_uart_tb_top;
  localparam int ETU = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       io_drv_low, irq;
  logic       card_low = 1'b0;
  wire        io_line = !(card_low || io_drv_low);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_char_uart dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .io_in(io_line),
    .io_drv_low(io_drv_low), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [8:0] enc(input logic [7:0] b, input bit inv);
    logic [8:0] l;
    for (int k = 0; k < 8; k++) l[k] = inv ? ~b[7-k] : b[k];
    l[8] = inv ? ~(^b) : (^b);
    return l;
  endfunction

  function automatic logic [7:0] dec(input logic [8:0] l, input bit inv);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = inv ? ~l[k] : l[7-k];
    return b;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; card_low = 1'b0;
    clks(3); rst = 1'b0; clks(2);
  endtask

  // card drives one character; reports whether the line was low at 11 ETU
  task automatic card_send(input logic [7:0] b, input bit inv, input bit badp, output bit pulse);
    logic [8:0] l;
    l = enc(b, inv);
    if (badp) l[8] = ~l[8];
    @(negedge clk);
    card_low = 1'b1; clks(ETU);
    for (int k = 0; k < 9; k++) begin
      card_low = ~l[k]; clks(ETU);
    end
    card_low = 1'b0; clks(ETU);
    pulse = !io_line;
    clks(ETU);
    if (pulse) clks(ETU);
  endtask

  task automatic wait_start(input int maxc, output bit got, output int t);
    got = 1'b0; t = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!io_line) begin got = 1'b1; t = cyc; break; end
    end
  endtask

  task automatic card_recv(input bit inv, input bit sig, output logic [7:0] b,
                           output bit pok, output int t, output bit got);
    logic [8:0] l;
    logic [8:0] lg;
    wait_start(6000, got, t);
    b = '0; pok = 1'b0;
    if (!got) return;
    clks(ETU / 2);
    for (int k = 0; k < 9; k++) begin
      clks(ETU); l[k] = io_line;
    end
    if (sig) begin
      clks(ETU / 2); card_low = 1'b1;
      clks(28); card_low = 1'b0; clks(4);
    end else begin
      clks(40);
    end
    lg = inv ? ~l : l;
    pok = ~(^lg);
    b = dec(l, inv);
  endtask

  initial begin
    logic [7:0] d, b, q [8];
    bit p, pok, got;
    int t, t0, t1, t2;
    void'($urandom(32'd7331));

    // ---------------- R1 reset state
    do_reset();
    check(io_drv_low == 1'b0, "R1 line released", io_drv_low, 0);
    check(irq == 1'b0, "R1 irq low", irq, 0);
    reg_rd(3'd0, d); check(d == 8'h07, "R1 ctrl reset", d, 8'h07);
    reg_rd(3'd1, d); check(d == 8'd16, "R1 etu reset", d, 16);
    reg_rd(3'd2, d); check(d == 8'd0, "R1 egt reset", d, 0);
    reg_rd(3'd5, d); check(d == 8'h20, "R1 status reset", d, 8'h20);

    // ---------------- R2 register read back
    reg_wr(3'd2, 8'd5); reg_rd(3'd2, d); check(d == 8'd5, "R2 egt rw", d, 5);
    reg_wr(3'd0, 8'h25); reg_rd(3'd0, d); check(d == 8'h25, "R2 ctrl rw", d, 8'h25);
    reg_wr(3'd0, 8'h87); reg_rd(3'd0, d); check(d == 8'h07, "R2 ctrl bit7 reads 0", d, 8'h07);
    reg_wr(3'd1, 8'd16); reg_rd(3'd1, d); check(d == 8'd16, "R2 etu rw", d, 16);
    reg_wr(3'd2, 8'd0);

    // ---------------- R3 direct initial character
    card_send(8'h3B, 1'b0, 1'b0, p);
    reg_rd(3'd5, d); check(d[1:0] == 2'b01, "R3 direct selected", d[1:0], 1);
    reg_rd(3'd4, d); check(d == 8'h3B, "R3 stored TS", d, 8'h3B);

    // ---------------- R5 random direct characters
    for (int i = 0; i < 16; i++) begin
      b = 8'($urandom());
      card_send(b, 1'b0, 1'b0, p);
      check(!p, "R5 no error pulse on good char", p, 0);
      reg_rd(3'd4, d); check(d == b, "R5 direct decode", d, b);
    end

    // ---------------- R6 T=0 parity error
    card_send(8'hA5, 1'b0, 1'b1, p);
    check(p, "R6 error pulse at 11 ETU", p, 1);
    reg_rd(3'd7, d); check(d == 8'd0, "R6 bad char discarded", d, 0);
    reg_rd(3'd6, d); check(d[3:0] == 4'd1, "R6 rx error counted", d[3:0], 1);

    // ---------------- R7 T=1 parity error
    reg_wr(3'd0, 8'h06);
    card_send(8'h5C, 1'b0, 1'b1, p);
    check(!p, "R7 no pulse with T=0 disabled", p, 0);
    reg_rd(3'd6, d); check(d[3:0] == 4'd2, "R7 rx error counted", d[3:0], 2);
    reg_rd(3'd4, d); check(d == 8'h5C, "R7 char stored", d, 8'h5C);
    reg_wr(3'd0, 8'h07);

    // ---------------- R11 threshold irq (threshold 3)
    reg_wr(3'd0, 8'h27);
    for (int i = 0; i < 3; i++) begin
      q[i] = 8'($urandom());
      card_send(q[i], 1'b0, 1'b0, p);
      clks(2);
      check(irq == (i == 2), "R11 irq vs count", irq, (i == 2));
    end
    reg_rd(3'd7, d); check(d == 8'd3, "R11 fifo count", d, 3);
    reg_rd(3'd4, d); clks(2);
    check(irq == 1'b0, "R11 irq drops below threshold", irq, 0);
    check(d == q[0], "R11 fifo order", d, q[0]);
    reg_rd(3'd4, d); reg_rd(3'd4, d);

    // ---------------- R12 overrun
    for (int i = 0; i < 8; i++) begin
      q[i] = 8'($urandom());
      card_send(q[i], 1'b0, 1'b0, p);
    end
    card_send(8'hEE, 1'b0, 1'b0, p);
    reg_rd(3'd5, d); check(d[4], "R12 overrun set", d[4], 1);
    reg_rd(3'd7, d); check(d == 8'd8, "R12 count at depth", d, 8);
    for (int i = 0; i < 8; i++) begin
      reg_rd(3'd4, d); check(d == q[i], "R12 contents kept", d, q[i]);
    end
    reg_wr(3'd0, 8'hA7);
    reg_rd(3'd5, d); check(!d[4], "R12 overrun cleared", d[4], 0);

    // ---------------- R8, R10 transmit, busy window (egt 2)
    reg_wr(3'd0, 8'h07);
    reg_wr(3'd2, 8'd2);
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom());
      reg_wr(3'd3, b);
      card_recv(1'b0, 1'b0, d, pok, t, got);
      check(got && d == b, "R8 direct tx data", d, b);
      check(pok, "R8 tx parity even", pok, 1);
      if (i == 0) begin
        reg_rd(3'd5, d); check(d[2], "R10 busy inside guard", d[2], 1);
        while (cyc < t + 14 * ETU + 8) @(negedge clk);
        reg_rd(3'd5, d); check(!d[2], "R10 idle after guard", d[2], 0);
      end else begin
        clks(4 * ETU);
      end
    end

    // ---------------- R13 write while busy ignored
    reg_wr(3'd3, 8'h11);
    reg_wr(3'd3, 8'h22);
    card_recv(1'b0, 1'b0, d, pok, t, got);
    check(d == 8'h11, "R13 first char sent", d, 8'h11);
    wait_start(30 * ETU, got, t);
    check(!got, "R13 second write ignored", got, 0);

    // ---------------- R9, R10 retransmission to limit (limit 2)
    reg_wr(3'd6, 8'h00);
    reg_wr(3'd0, 8'h05);
    reg_wr(3'd3, 8'h6D);
    card_recv(1'b0, 1'b1, d, pok, t0, got);
    card_recv(1'b0, 1'b1, d, pok, t1, got);
    check(got && d == 8'h6D, "R9 resend same char", d, 8'h6D);
    check(t1 - t0 == 15 * ETU, "R10 resend spacing", t1 - t0, 15 * ETU);
    card_recv(1'b0, 1'b1, d, pok, t2, got);
    check(got && t2 - t1 == 15 * ETU, "R10 second resend spacing", t2 - t1, 15 * ETU);
    wait_start(30 * ETU, got, t);
    check(!got, "R9 stops at limit", got, 0);
    reg_rd(3'd5, d); check(d[3], "R9 fail flag", d[3], 1);
    reg_rd(3'd6, d); check(d[7:4] == 4'd3, "R9 tx error count", d[7:4], 3);

    // one error then success
    reg_wr(3'd0, 8'h85);
    reg_wr(3'd3, 8'hC3);
    card_recv(1'b0, 1'b1, d, pok, t0, got);
    card_recv(1'b0, 1'b0, d, pok, t1, got);
    check(got && d == 8'hC3, "R9 retry accepted", d, 8'hC3);
    clks(4 * ETU);
    reg_rd(3'd5, d); check(!d[3], "R9 no fail after recovery", d[3], 0);

    // ---------------- R14 clear counts
    reg_wr(3'd6, 8'h5A);
    reg_rd(3'd6, d); check(d == 8'h00, "R14 counts cleared", d, 0);

    // ---------------- R4 inverse convention
    do_reset();
    card_send(8'h3F, 1'b1, 1'b0, p);
    reg_rd(3'd5, d); check(d[1:0] == 2'b11, "R4 inverse selected", d[1:0], 3);
    reg_rd(3'd4, d); check(d == 8'h3F, "R4 stored TS", d, 8'h3F);
    for (int i = 0; i < 8; i++) begin
      b = 8'($urandom());
      card_send(b, 1'b1, 1'b0, p);
      check(!p, "R4 no pulse on good inverse char", p, 0);
      reg_rd(3'd4, d); check(d == b, "R4 inverse rx decode", d, b);
    end
    card_send(8'h81, 1'b1, 1'b1, p);
    check(p, "R6 inverse parity error pulse", p, 1);
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom());
      reg_wr(3'd3, b);
      card_recv(1'b1, 1'b0, d, pok, t, got);
      check(got && d == b, "R4 inverse tx data", d, b);
      check(pok, "R4 inverse tx parity", pok, 1);
      clks(2 * ETU);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule